// File: doc/BRIEF.md
# Interrupt Request Gating and Priority Selector

This block gathers a small group of level-sensitive interrupt sources into a pending word. It qualifies that word against a per-line enable mask and decides whether the core should take an interrupt. Hardware sources are sampled every clock and follow their input level with no latching. The two lowest positions are software-owned bits. They change only through an indexed write port that sets or clears one bit at a time. A separate write port loads the per-line enable mask.

Three outputs are derived from the masked pending word. A wake indication shows that there is work pending, whatever the global enable is. A take-interrupt request is the wake indication further gated by the global enable and blocked while the core is in debug state. A binary vector number names the highest-numbered line that is both pending and enabled. The surrounding core uses the request to enter its interrupt handler and the vector to select the handler. It uses the wake indication to leave a low-power wait.

Top module: `irq_gate`

## Requirements
- R1: Each hardware line `hwLines[k]` appears in `pendOut[NUM_SW+k]` (positions 2 to 12 by default) on the clock edge after it is sampled, and follows the line low as well as high.
- R2: A write with `swWrEn=1` and `swWrIdx` below `NUM_SW` (0 or 1) loads `swWrLevel` into that software bit of `pendOut`, which is visible after the next clock edge and held until rewritten.
- R3: A software write whose index addresses a hardware position (2 to 12) or lies beyond the last line (13 to 15) leaves every bit of `pendOut` unchanged apart from the hardware-line sampling of R1.
- R4: `maskWrEn=1` loads `maskWrData` into the enable mask on the next edge. Only lines whose mask bit is 1 count as pending for R5 to R7.
- R5: `wakeOut` is 1 exactly when the bitwise AND of `pendOut` and the mask is non-zero, independent of `globalEn` and `debugState`.
- R6: `takeReq` is 1 exactly when `wakeOut` is 1, `globalEn` is 1 and `debugState` is 0.
- R7: While `takeReq` is 1, `vecOut` holds the index of the most significant bit set in the masked pending word.
- R8: While `takeReq` is 0, `vecOut` is 0.
- R9: During and directly after reset, the mask is 0 and all of `pendOut` is 0, so `wakeOut`, `takeReq` and `vecOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwLines | input | NUM_LINES-NUM_SW (11) | Level-sensitive hardware interrupt lines, bit k maps to pending position NUM_SW+k |
| swWrEn | input | 1 | Strobe for the indexed software-bit write |
| swWrIdx | input | 4 | Pending position addressed by the software write |
| swWrLevel | input | 1 | Value written to the addressed software bit |
| maskWrEn | input | 1 | Strobe that loads the enable mask |
| maskWrData | input | NUM_LINES (13) | New enable mask, one bit per line |
| globalEn | input | 1 | Global interrupt enable |
| debugState | input | 1 | Core is in debug state; blocks the request |
| pendOut | output | NUM_LINES (13) | Pending-status word |
| takeReq | output | 1 | Take-interrupt request |
| wakeOut | output | 1 | Work-pending indication for wait exit |
| vecOut | output | 4 | Winning line number, 0 when no request |

## Verification
A software-bit write, a change of the hardware lines and a mask reload can all land on the same clock edge. Each changes a different part of the masked word that drives the wake, the request and the vector. The sweep drives all three together: the software index and level come from the low bits of the hardware pattern, and a mask reload is placed inside the hardware sweep. After each edge the bench rebuilds the pending word and the mask from the requirements and compares all four outputs. Debug state and the global enable are toggled in the same cycles, so wake-without-request cases appear next to request cases with the same masked word.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  // width of the indexed software-write address
  localparam int IRQ_IDX_W = 4;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic                 swLoad;   // load one software pending bit
    logic [IRQ_IDX_W-1:0] swSel;    // which software bit
    logic                 swVal;    // value to load
    logic                 maskLoad; // load the enable mask
  } irqStrobes_t;

endpackage

// File: rtl/irq_gate_dp.sv
module irq_gate_dp
  import irq_gate_pkg::*;
#(
  parameter int NUM_LINES = 13,
  parameter int NUM_SW    = 2,
  localparam int HW_W     = NUM_LINES - NUM_SW,
  localparam int VEC_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  irqStrobes_t          strb,
  input  logic [NUM_LINES-1:0] maskWrData,
  input  logic [HW_W-1:0]      hwLines,
  output logic [NUM_LINES-1:0] pendQ,
  output logic [NUM_LINES-1:0] maskQ,
  output logic                 anyMasked,
  output logic [VEC_W-1:0]     rawVec
);

  logic [NUM_LINES-1:0] maskedPend;

  // software-owned pending bits, one register each
  for (genvar g = 0; g < NUM_SW; g++) begin : g_sw
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ[g] <= 1'b0;
      end else if (strb.swLoad && (strb.swSel == IRQ_IDX_W'(g))) begin
        pendQ[g] <= strb.swVal;
      end
    end
  end

  // hardware-owned pending bits follow their lines each cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ[NUM_LINES-1:NUM_SW] <= '0;
    end else begin
      pendQ[NUM_LINES-1:NUM_SW] <= hwLines;
    end
  end

  // per-line enable mask
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (strb.maskLoad) begin
      maskQ <= maskWrData;
    end
  end

  assign maskedPend = pendQ & maskQ;
  assign anyMasked  = |maskedPend;

  // highest set index wins: later iterations override earlier ones
  always_comb begin
    rawVec = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (maskedPend[i]) begin
        rawVec = VEC_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
#(
  parameter int NUM_LINES = 13,
  parameter int NUM_SW    = 2,
  localparam int VEC_W    = $clog2(NUM_LINES)
) (
  input  logic                 swWrEn,
  input  logic [IRQ_IDX_W-1:0] swWrIdx,
  input  logic                 swWrLevel,
  input  logic                 maskWrEn,
  input  logic                 anyMasked,
  input  logic [VEC_W-1:0]     rawVec,
  input  logic                 globalEn,
  input  logic                 debugState,
  output irqStrobes_t          strb,
  output logic                 takeReq,
  output logic                 wakeOut,
  output logic [VEC_W-1:0]     vecOut
);

  localparam logic [IRQ_IDX_W:0] SW_LIMIT = (IRQ_IDX_W+1)'(NUM_SW);

  logic idxIsSw;

  // hardware positions and out-of-range indices never reach the datapath
  assign idxIsSw = ({1'b0, swWrIdx} < SW_LIMIT);

  always_comb begin
    strb          = '0;
    strb.swLoad   = swWrEn && idxIsSw;
    strb.swSel    = swWrIdx;
    strb.swVal    = swWrLevel;
    strb.maskLoad = maskWrEn;
  end

  // wake ignores the enables; the request does not
  assign wakeOut = anyMasked;
  assign takeReq = anyMasked && globalEn && !debugState;
  assign vecOut  = takeReq ? rawVec : '0;

endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_gate_pkg::*;
#(
  parameter int NUM_LINES = 13,
  parameter int NUM_SW    = 2,
  localparam int HW_W     = NUM_LINES - NUM_SW,
  localparam int VEC_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [HW_W-1:0]      hwLines,
  input  logic                 swWrEn,
  input  logic [IRQ_IDX_W-1:0] swWrIdx,
  input  logic                 swWrLevel,
  input  logic                 maskWrEn,
  input  logic [NUM_LINES-1:0] maskWrData,
  input  logic                 globalEn,
  input  logic                 debugState,
  output logic [NUM_LINES-1:0] pendOut,
  output logic                 takeReq,
  output logic                 wakeOut,
  output logic [VEC_W-1:0]     vecOut
);

  irqStrobes_t          strb;
  logic [NUM_LINES-1:0] maskQ;
  logic                 anyMasked;
  logic [VEC_W-1:0]     rawVec;

  irq_gate_ctrl #(.NUM_LINES(NUM_LINES), .NUM_SW(NUM_SW)) ctrl_i (
    .swWrEn     (swWrEn),
    .swWrIdx    (swWrIdx),
    .swWrLevel  (swWrLevel),
    .maskWrEn   (maskWrEn),
    .anyMasked  (anyMasked),
    .rawVec     (rawVec),
    .globalEn   (globalEn),
    .debugState (debugState),
    .strb       (strb),
    .takeReq    (takeReq),
    .wakeOut    (wakeOut),
    .vecOut     (vecOut)
  );

  irq_gate_dp #(.NUM_LINES(NUM_LINES), .NUM_SW(NUM_SW)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .maskWrData (maskWrData),
    .hwLines    (hwLines),
    .pendQ      (pendOut),
    .maskQ      (maskQ),
    .anyMasked  (anyMasked),
    .rawVec     (rawVec)
  );

endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk
  import irq_gate_pkg::*;
#(
  parameter int NUM_LINES = 13,
  parameter int NUM_SW    = 2,
  localparam int HW_W     = NUM_LINES - NUM_SW,
  localparam int VEC_W    = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [HW_W-1:0]      hwLines,
  input logic                 swWrEn,
  input logic [IRQ_IDX_W-1:0] swWrIdx,
  input logic                 maskWrEn,
  input logic [NUM_LINES-1:0] maskWrData,
  input logic                 globalEn,
  input logic                 debugState,
  input logic [NUM_LINES-1:0] pendOut,
  input logic                 takeReq,
  input logic                 wakeOut,
  input logic [VEC_W-1:0]     vecOut,
  input logic [NUM_LINES-1:0] maskQ
);

  localparam logic [IRQ_IDX_W-1:0] SW_LIM = IRQ_IDX_W'(NUM_SW);

  logic [NUM_LINES-1:0] maskedWord;
  logic                 prevRun;

  assign maskedWord = pendOut & maskQ;

  // one-cycle history of the reset, so $past is only used after a live cycle
  always_ff @(posedge clk) begin
    prevRun <= rstN;
  end

  AST_HW_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    prevRun |-> pendOut[NUM_LINES-1:NUM_SW] == $past(hwLines)); // R1

  AST_SW_IDX_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (prevRun && $past(swWrEn) && ($past(swWrIdx) >= SW_LIM))
      |-> pendOut[NUM_SW-1:0] == $past(pendOut[NUM_SW-1:0])); // R3

  AST_SW_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (prevRun && !$past(swWrEn)) |-> $stable(pendOut[NUM_SW-1:0])); // R2

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (prevRun && $past(maskWrEn)) |-> maskQ == $past(maskWrData)); // R4

  AST_WAKE_ANY: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut == (maskedWord != '0)); // R5

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |-> (wakeOut && globalEn && !debugState)); // R6

  AST_VEC_TOPMOST: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |-> ((maskedWord >> vecOut) == NUM_LINES'(1))); // R7

  AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !takeReq |-> vecOut == '0); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !prevRun |-> (maskQ == '0 && pendOut == '0)); // R9

endmodule

bind irq_gate irq_gate_chk #(.NUM_LINES(NUM_LINES), .NUM_SW(NUM_SW)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .hwLines    (hwLines),
  .swWrEn     (swWrEn),
  .swWrIdx    (swWrIdx),
  .maskWrEn   (maskWrEn),
  .maskWrData (maskWrData),
  .globalEn   (globalEn),
  .debugState (debugState),
  .pendOut    (pendOut),
  .takeReq    (takeReq),
  .wakeOut    (wakeOut),
  .vecOut     (vecOut),
  .maskQ      (maskQ)
);

// File: tb/irq_gate_tb_top.sv
`timescale 1ns/1ps
module irq_gate_tb_top;

  localparam int NL  = 13;
  localparam int NS  = 2;
  localparam int HW  = NL - NS;
  localparam int VW  = $clog2(NL);

  logic          clk = 1'b0;
  logic          rstN;
  logic [HW-1:0] hwLines;
  logic          swWrEn;
  logic [3:0]    swWrIdx;
  logic          swWrLevel;
  logic          maskWrEn;
  logic [NL-1:0] maskWrData;
  logic          globalEn;
  logic          debugState;
  logic [NL-1:0] pendOut;
  logic          takeReq;
  logic          wakeOut;
  logic [VW-1:0] vecOut;

  int compared = 0;
  int mismatched = 0;
  logic [NL-1:0] mPend;
  logic [NL-1:0] mMask;

  always #5 clk = ~clk;

  irq_gate #(.NUM_LINES(NL), .NUM_SW(NS)) dut_i (
    .clk(clk), .rstN(rstN), .hwLines(hwLines), .swWrEn(swWrEn),
    .swWrIdx(swWrIdx), .swWrLevel(swWrLevel), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .globalEn(globalEn), .debugState(debugState),
    .pendOut(pendOut), .takeReq(takeReq), .wakeOut(wakeOut), .vecOut(vecOut)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    logic [NL-1:0] mw;
    logic eWake;
    logic eReq;
    int eVec;
    mw = mPend & mMask;
    eWake = (mw != '0);
    eReq = eWake && globalEn && !debugState;
    eVec = 0;
    if (eReq) begin
      for (int i = 0; i < NL; i++) if (mw[i]) eVec = i;
    end
    cmp("R1 R2 R3 pending word", int'(pendOut), int'(mPend));
    cmp("R4 R5 wake", int'(wakeOut), int'(eWake));
    cmp("R6 request", int'(takeReq), int'(eReq));
    cmp("R7 R8 vector", int'(vecOut), eVec);
  endtask

  // one cycle: drive at negedge, update model at posedge, compare 2 ns later
  task automatic step(input logic [HW-1:0] hw, input logic sEn,
                      input logic [3:0] sIdx, input logic sLvl,
                      input logic mEn, input logic [NL-1:0] mDat,
                      input logic ge, input logic dbg);
    @(negedge clk);
    hwLines = hw; swWrEn = sEn; swWrIdx = sIdx; swWrLevel = sLvl;
    maskWrEn = mEn; maskWrData = mDat; globalEn = ge; debugState = dbg;
    @(posedge clk);
    mPend[NL-1:NS] = hw;
    if (sEn && sIdx < 4'(NS)) mPend[sIdx] = sLvl;
    if (mEn) mMask = mDat;
    #2;
    checkAll();
  endtask

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [NL-1:0] masks [4];
    masks[0] = 13'h1FFF; masks[1] = 13'h0AAA; masks[2] = 13'h1555; masks[3] = 13'h1003;
    rstN = 1'b0; hwLines = '1; swWrEn = 1'b1; swWrIdx = 4'd0; swWrLevel = 1'b1;
    maskWrEn = 1'b1; maskWrData = '1; globalEn = 1'b1; debugState = 1'b0;
    mPend = '0; mMask = '0;
    repeat (3) @(posedge clk);
    #2;
    // R9: reset clears mask and pending regardless of active write ports
    cmp("R9 pending in reset", int'(pendOut), 0);
    cmp("R9 wake in reset", int'(wakeOut), 0);
    cmp("R9 request in reset", int'(takeReq), 0);
    cmp("R9 vector in reset", int'(vecOut), 0);
    @(negedge clk);
    rstN = 1'b1; swWrEn = 1'b0; maskWrEn = 1'b0; hwLines = '0;
    @(posedge clk); #2;
    checkAll();
    // R9: mask held at zero after reset, so a raised line gives no wake
    step('1, 1'b0, 4'd0, 1'b0, 1'b0, '0, 1'b1, 1'b0);
    cmp("R9 mask zero after reset", int'(wakeOut), 0);

    // R2/R3: every software index, set then clear, with all lines enabled
    step('0, 1'b0, 4'd0, 1'b0, 1'b1, '1, 1'b1, 1'b0);
    for (int lvl = 1; lvl >= 0; lvl--) begin
      for (int idx = 0; idx < 16; idx++) begin
        step('0, 1'b1, 4'(idx), 1'(lvl), 1'b0, '0, 1'b1, 1'b0);
        step('0, 1'b0, 4'(idx), 1'(lvl), 1'b0, '0, 1'b1, 1'b0);
      end
    end

    // full hardware sweep under several masks, with concurrent software
    // writes, a mid-sweep mask reload, and enable/debug variation
    for (int m = 0; m < 4; m++) begin
      step('0, 1'b0, 4'd0, 1'b0, 1'b1, masks[m], 1'b1, 1'b0);
      for (int h = 0; h < (1 << HW); h++) begin
        logic [HW-1:0] hv;
        hv = HW'(h);
        step(hv, hv[0] ^ hv[3], 4'(h % 16), hv[1], (h == 1024),
             masks[(m + 1) % 4], !(hv[5] & hv[6]), hv[7] & hv[8]);
      end
    end

    // R1: a line dropping clears its pending bit the next cycle
    step(11'h7FF, 1'b0, 4'd0, 1'b0, 1'b1, '1, 1'b1, 1'b0);
    step(11'h000, 1'b0, 4'd0, 1'b0, 1'b0, '0, 1'b1, 1'b0);
    cmp("R1 line drop clears", int'(pendOut[NL-1:NS]), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule